// File: doc/BRIEF.md
# Dual-clock first-word-fall-through FIFO

This block buffers 18-bit words between two clock domains. A producer on the write clock pushes words, and a consumer on the read clock pops them. The two clocks run continuously. They may be unrelated or they may be one and the same clock. Storage is a 512-entry array, and one more word sits in the output register, so 513 words can be held in total.

The output works in fall-through mode. When the FIFO is empty and a word is written, that word is moved into the output register on its own, with no read request. The output-ready flag then rises to show that the output holds valid data.

A write needs both write enables to agree: one is active high and the other active low. A read needs the read enable and both output enables to be low. The write side also reports a half-full flag and an almost-full/almost-empty flag, whose threshold is a parameter.

A single active-low reset clears both domains. Each domain samples the reset on its own clock edges, so the reset must be held low for at least four rising edges of each clock.

Top module: `fifo_fwft_dc`

## Requirements
- R1: The FIFO accepts exactly 513 words (DEPTH=512 array entries plus the output register) before input-ready falls, and it returns every accepted 18-bit word in the order it was written.
- R2: A word is taken on a write-clock rising edge only when wr_en_hi=1, wr_en_lo_n=0 and in_rdy=1. With any other combination, no word enters the FIFO.
- R3: A word is removed on a read-clock rising edge only when rd_en_n=0, oe_a_n=0, oe_b_n=0 and out_rdy=1. Otherwise rd_data and out_rdy hold their values.
- R4: When the FIFO is empty, the first word written appears on rd_data with out_rdy=1 within 6 read-clock cycles, even with every read and output enable held high.
- R5: Whenever out_rdy=1, rd_data equals the oldest word that has been accepted and not yet removed.
- R6: While rst_n=0 across at least four edges of each clock, in_rdy=0, out_rdy=0, half_full=0 and almost_fe=1, and every stored word is discarded.
- R7: in_rdy rises on the first write-clock edge after reset is released. It is never 1 while 513 words are held, and it returns to 1 after reads free space.
- R8: Once the flags have settled, half_full=1 exactly when 257 or more words are held, counting the output register.
- R9: Once the flags have settled, almost_fe=1 exactly when the held count is at most ALMOST_OFS or at least 513-ALMOST_OFS. ALMOST_OFS defaults to 64, giving the thresholds 64 and 449.
- R10: A write and a read on the same rising edge of a shared clock both take effect, with no word lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled on both clocks |
| wr_en_hi | input | 1 | Write enable, active high |
| wr_en_lo_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Word to write |
| in_rdy | output | 1 | Space available (write domain) |
| rd_en_n | input | 1 | Read enable, active low |
| oe_a_n | input | 1 | First output enable, active low |
| oe_b_n | input | 1 | Second output enable, active low |
| rd_data | output | 18 | Output register contents |
| out_rdy | output | 1 | Output register valid (read domain) |
| half_full | output | 1 | 257 or more words held (write domain) |
| almost_fe | output | 1 | Count within the offset of empty or full (write domain) |

## Verification
The two functions that can fall in the same cycle are a push on the write side and a pop or refill of the output register on the read side. Both clocks are driven from one source so that both land on the same edge. Long stretches of pseudo-random enable patterns then give many edges where a write and a read happen together, including at a nearly empty and a nearly full FIFO. They are judged by a queue model that applies the pop before the push, and on every cycle the output word is compared with the head of that queue. The flag levels are checked after idle periods at the exact threshold counts.

// File: rtl/fifo_fwft_pkg.sv
// Package: shared flag type and the write-side flag rule.
// Assumes counts are passed as zero-extended unsigned integers.
package fifo_fwft_pkg;

    // Flags registered in the write-clock domain.
    typedef struct packed {
        logic in_rdy;
        logic half;
        logic almost;
    } wr_flags_t;

    // Derive the write-side flags from the total occupancy (output register
    // included) and the occupancy of the storage array alone.
    function automatic wr_flags_t calc_wr_flags(
        input int unsigned occ,
        input int unsigned ram_occ,
        input int unsigned depth,
        input int unsigned ofs
    );
        wr_flags_t   f;
        int unsigned cap;
        cap      = depth + 1;
        f.in_rdy = (occ < cap) && (ram_occ < depth);
        f.half   = (occ >= (depth / 2) + 1);
        f.almost = (occ <= ofs) || ((occ + ofs) >= cap);
        return f;
    endfunction

endpackage

// File: rtl/fifo_ptr_cdc.sv
// Pointer crossing: turns a binary pointer into Gray code in the source
// domain, passes it through a chain of STAGES flops in the destination
// domain, and turns it back into binary there.
// Assumes the source pointer changes by at most one per source clock.
module fifo_ptr_cdc #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_bin,
    output logic [W-1:0] dst_bin
);

    logic [W-1:0] src_gray;
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] dst_gray;

    // Register the Gray form in the source domain so that only one bit toggles.
    always_ff @(posedge src_clk) begin
        if (!rst_n) src_gray <= '0;
        else        src_gray <= src_bin ^ (src_bin >> 1);
    end

    // Synchronizer chain in the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= src_gray;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dst_gray = chain[STAGES-1];

    // Gray to binary: each binary bit is the XOR of the Gray bits at or above it.
    for (genvar b = 0; b < W; b++) begin : g_g2b
        assign dst_bin[b] = ^(dst_gray >> b);
    end

endmodule

// File: rtl/fifo_mem.sv
// Storage array: one synchronous write port on the write clock and one
// combinational read port. The entries are not reset.
// Assumes an entry is never read in the cycle it is written; the pointer
// crossing latency guarantees this.
module fifo_mem #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port.
    assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_wr_ctrl.sv
// Write-side control: qualifies the write with both enables and the
// ready flag, advances the write pointer, and registers in-ready,
// half-full and almost-full/almost-empty from the next pointer and the
// synchronized read-side pointers.
// Assumes the synchronized pointers only lag their true values, so the
// flags err on the safe side.
module fifo_wr_ctrl
    import fifo_fwft_pkg::*;
#(
    parameter int DEPTH      = 512,
    parameter int ALMOST_OFS = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en_hi,
    input  logic              wr_en_lo_n,
    input  logic [PTR_W-1:0]  cons_sync,
    input  logic [PTR_W-1:0]  fetch_sync,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              in_rdy,
    output logic              half_full,
    output logic              almost_fe
);

    logic             wr_fire;
    logic [PTR_W-1:0] ptr_nxt;
    logic [PTR_W-1:0] occ;
    logic [PTR_W-1:0] ram_occ;
    wr_flags_t        flags_nxt;

    // Qualify the write and work out the flags for the next cycle.
    always_comb begin
        wr_fire   = in_rdy & wr_en_hi & ~wr_en_lo_n;
        ptr_nxt   = wr_ptr + PTR_W'(wr_fire);
        occ       = ptr_nxt - cons_sync;
        ram_occ   = ptr_nxt - fetch_sync;
        flags_nxt = calc_wr_flags(32'(occ), 32'(ram_occ), DEPTH, ALMOST_OFS);
    end

    // Pointer and flag registers.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            in_rdy    <= 1'b0;
            half_full <= 1'b0;
            almost_fe <= 1'b1;
        end else begin
            wr_ptr    <= ptr_nxt;
            in_rdy    <= flags_nxt.in_rdy;
            half_full <= flags_nxt.half;
            almost_fe <= flags_nxt.almost;
        end
    end

    assign mem_we    = wr_fire;
    assign mem_waddr = wr_ptr[ADDR_W-1:0];

endmodule

// File: rtl/fifo_rd_ctrl.sv
// Read-side control: keeps the output register filled from the array
// (fall-through), qualifies reads with the read enable and both output
// enables, and keeps the fetch pointer (words moved into the output
// register) and the consume pointer (words removed by reads).
// Assumes the write pointer input is already synchronized to rd_clk.
module fifo_rd_ctrl #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic [PTR_W-1:0]  wr_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [PTR_W-1:0]  fetch_ptr,
    output logic [PTR_W-1:0]  cons_ptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_rdy
);

    logic ram_has;
    logic rd_fire;
    logic load;

    // Decide whether to pop the output and whether to refill it.
    always_comb begin
        ram_has = (wr_sync != fetch_ptr);
        rd_fire = out_rdy & ~rd_en_n & ~oe_a_n & ~oe_b_n;
        load    = ram_has & (~out_rdy | rd_fire);
    end

    // Output register, valid flag and the two read-side pointers.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            fetch_ptr <= '0;
            cons_ptr  <= '0;
            rd_data   <= '0;
            out_rdy   <= 1'b0;
        end else begin
            if (load) begin
                rd_data   <= mem_rdata;
                fetch_ptr <= fetch_ptr + 1'b1;
            end
            if (rd_fire) cons_ptr <= cons_ptr + 1'b1;
            out_rdy <= load | (out_rdy & ~rd_fire);
        end
    end

    assign mem_raddr = fetch_ptr[ADDR_W-1:0];

endmodule

// File: rtl/fifo_fwft_dc.sv
// Dual-clock fall-through FIFO top: array, write control, read control
// and three pointer crossings (write pointer to the read side; fetch and
// consume pointers to the write side).
// Assumes rst_n is held low for at least four edges of each clock.
module fifo_fwft_dc #(
    parameter int DATA_W      = 18,
    parameter int DEPTH       = 512,
    parameter int ALMOST_OFS  = 64,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_hi,
    input  logic              wr_en_lo_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic              in_rdy,
    input  logic              rd_en_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_rdy,
    output logic              half_full,
    output logic              almost_fe
);

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  wr_sync;
    logic [PTR_W-1:0]  fetch_ptr;
    logic [PTR_W-1:0]  fetch_sync;
    logic [PTR_W-1:0]  cons_ptr;
    logic [PTR_W-1:0]  cons_sync;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;

    fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wr_data),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    fifo_wr_ctrl #(.DEPTH(DEPTH), .ALMOST_OFS(ALMOST_OFS)) u_wr (
        .wr_clk     (wr_clk),
        .rst_n      (rst_n),
        .wr_en_hi   (wr_en_hi),
        .wr_en_lo_n (wr_en_lo_n),
        .cons_sync  (cons_sync),
        .fetch_sync (fetch_sync),
        .wr_ptr     (wr_ptr),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .in_rdy     (in_rdy),
        .half_full  (half_full),
        .almost_fe  (almost_fe)
    );

    fifo_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .rd_clk    (rd_clk),
        .rst_n     (rst_n),
        .rd_en_n   (rd_en_n),
        .oe_a_n    (oe_a_n),
        .oe_b_n    (oe_b_n),
        .wr_sync   (wr_sync),
        .mem_rdata (mem_rdata),
        .mem_raddr (mem_raddr),
        .fetch_ptr (fetch_ptr),
        .cons_ptr  (cons_ptr),
        .rd_data   (rd_data),
        .out_rdy   (out_rdy)
    );

    fifo_ptr_cdc #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_cdc_wr (
        .src_clk (wr_clk),
        .dst_clk (rd_clk),
        .rst_n   (rst_n),
        .src_bin (wr_ptr),
        .dst_bin (wr_sync)
    );

    fifo_ptr_cdc #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_cdc_fetch (
        .src_clk (rd_clk),
        .dst_clk (wr_clk),
        .rst_n   (rst_n),
        .src_bin (fetch_ptr),
        .dst_bin (fetch_sync)
    );

    fifo_ptr_cdc #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_cdc_cons (
        .src_clk (rd_clk),
        .dst_clk (wr_clk),
        .rst_n   (rst_n),
        .src_bin (cons_ptr),
        .dst_bin (cons_sync)
    );

endmodule

// File: rtl/fifo_fwft_dc_chk.sv
// Checker for fifo_fwft_dc: temporal properties on the ports and on the
// pointers, attached to the top module by the bind statement below.
module fifo_fwft_dc_chk #(
    parameter int DATA_W = 18,
    parameter int PTR_W  = 10
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              wr_en_hi,
    input logic              wr_en_lo_n,
    input logic              in_rdy,
    input logic              half_full,
    input logic              rd_en_n,
    input logic              oe_a_n,
    input logic              oe_b_n,
    input logic              out_rdy,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [PTR_W-1:0]  cons_ptr
);

    logic rd_req;
    assign rd_req = out_rdy & ~rd_en_n & ~oe_a_n & ~oe_b_n;

    // R3: without a qualified read, the output word and its valid flag hold.
    a_r3_out_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (out_rdy && !rd_req) |=> (out_rdy && $stable(rd_data)));

    // R3: the consume pointer moves only after a fully qualified read.
    a_r3_no_pop: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_req |=> $stable(cons_ptr));

    // R2: with in_rdy low, no write reaches the array.
    a_r2_no_write_blocked: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !in_rdy |=> $stable(wr_ptr));

    // R5: the output goes invalid only after a read has taken its word.
    a_r5_valid_until_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $fell(out_rdy) |-> $past(rd_req));

    // R8: half-full can only rise after an accepted write.
    a_r8_half_rise_on_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(half_full) |-> $past(in_rdy && wr_en_hi && !wr_en_lo_n));

endmodule

bind fifo_fwft_dc fifo_fwft_dc_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .wr_clk     (wr_clk),
    .rd_clk     (rd_clk),
    .rst_n      (rst_n),
    .wr_en_hi   (wr_en_hi),
    .wr_en_lo_n (wr_en_lo_n),
    .in_rdy     (in_rdy),
    .half_full  (half_full),
    .rd_en_n    (rd_en_n),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .out_rdy    (out_rdy),
    .rd_data    (rd_data),
    .wr_ptr     (wr_ptr),
    .cons_ptr   (cons_ptr)
);

// File: tb/test_fifo_fwft_dc.sv
// Bench for fifo_fwft_dc: one 125 MHz clock drives both domains. A queue
// model is updated on every clock and compared with the output word.
module test_fifo_fwft_dc;

    localparam int DW  = 18;
    localparam int CAP = 513;
    localparam int OFS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_hi = 1'b0;
    logic          wr_en_lo_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          oe_a_n = 1'b1;
    logic          oe_b_n = 1'b1;
    logic          in_rdy, out_rdy, half_full, almost_fe;
    logic [DW-1:0] rd_data;

    int            n_checks = 0;
    int            n_fail   = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] next_word = 18'h00100;
    logic [31:0]   seed = 32'h1234_5678;

    always #4 clk = ~clk;

    fifo_fwft_dc i_fifo_fwft_dc (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_en_hi(wr_en_hi), .wr_en_lo_n(wr_en_lo_n), .wr_data(wr_data),
        .in_rdy(in_rdy), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .rd_data(rd_data), .out_rdy(out_rdy),
        .half_full(half_full), .almost_fe(almost_fe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: compare at the falling edge, drive, then update the model.
    task automatic step(input logic whi, input logic wlon, input logic ren, input logic oea, input logic oeb);
        bit wf, rf;
        @(negedge clk);
        if (out_rdy) begin
            chk(q.size() > 0, "R5 valid with empty model", 32'(q.size()), 32'd1);
            if (q.size() > 0) chk(rd_data === q[0], "R5 output word", 32'(rd_data), 32'(q[0]));
        end
        if (in_rdy) chk(q.size() < CAP, "R7 ready while full", 32'(q.size()), CAP - 1);
        wf = in_rdy && whi && !wlon;
        rf = out_rdy && !ren && !oea && !oeb;
        wr_en_hi = whi; wr_en_lo_n = wlon; wr_data = next_word;
        rd_en_n = ren; oe_a_n = oea; oe_b_n = oeb;
        if (rf) void'(q.pop_front());
        if (wf) begin
            q.push_back(next_word);
            next_word = next_word + 18'd7;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    // Let the crossings settle, then compare every flag with the count.
    task automatic settle_check(input string tag);
        int n;
        idle(10);
        n = q.size();
        chk(in_rdy == (n < CAP), {tag, " R7 in_rdy"}, 32'(in_rdy), 32'(n < CAP));
        chk(half_full == (n >= 257), {tag, " R8 half_full"}, 32'(half_full), 32'(n >= 257));
        chk(almost_fe == (n <= OFS || n >= CAP - OFS), {tag, " R9 almost_fe"},
            32'(almost_fe), 32'(n <= OFS || n >= CAP - OFS));
        chk(out_rdy == (n > 0), {tag, " R4 out_rdy"}, 32'(out_rdy), 32'(n > 0));
    endtask

    task automatic fill_to(input int target);
        for (int g = 0; g < 4000 && q.size() < target; g++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(q.size() == target, "R1 fill count", 32'(q.size()), 32'(target));
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b1; rd_en_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(in_rdy == 1'b0, "R6 in_rdy in reset", 32'(in_rdy), 0);
        chk(out_rdy == 1'b0, "R6 out_rdy in reset", 32'(out_rdy), 0);
        chk(half_full == 1'b0, "R6 half_full in reset", 32'(half_full), 0);
        chk(almost_fe == 1'b1, "R6 almost_fe in reset", 32'(almost_fe), 1);
        q.delete();
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_rdy == 1'b1, "R7 in_rdy after release", 32'(in_rdy), 1);
    endtask

    initial begin
        int lat;
        logic [DW-1:0] first;
        do_reset();
        settle_check("empty");

        // R2: each half-qualified write is ignored.
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        idle(10);
        chk(out_rdy == 1'b0, "R2 unqualified write ignored", 32'(out_rdy), 0);

        // R4: the first word falls through with every read enable high.
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        first = q[0];
        lat = 0;
        while (!out_rdy && lat < 20) begin idle(1); lat++; end
        chk(lat <= 6, "R4 fall-through latency", 32'(lat), 6);
        chk(rd_data === first, "R4 fall-through word", 32'(rd_data), 32'(first));

        // R3: each single enable high blocks the read.
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        idle(1);
        chk(out_rdy && rd_data === first, "R3 blocked read holds word", 32'(rd_data), 32'(first));

        // R8, R9, R1: thresholds while filling without reads.
        fill_to(OFS);           settle_check("at 64");
        fill_to(OFS + 1);       settle_check("at 65");
        fill_to(256);           settle_check("at 256");
        fill_to(257);           settle_check("at 257");
        fill_to(CAP - OFS - 1); settle_check("at 448");
        fill_to(CAP - OFS);     settle_check("at 449");
        for (int i = 0; i < 600; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(q.size() == CAP, "R1 capacity", 32'(q.size()), CAP);
        settle_check("full");

        // R10: random simultaneous writes and reads on one shared clock.
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            step(seed[20], seed[21] & seed[25], seed[22] & seed[26], seed[23] & seed[27], 1'b0);
        end
        settle_check("R10 after mixed traffic");

        // Drain everything in order, then the empty flags.
        for (int g = 0; g < 2000 && (q.size() > 0 || out_rdy); g++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        settle_check("drained");

        // R10: steady write and read on every edge, near empty.
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        settle_check("R10 streaming");

        // R6: reset with data held discards it.
        fill_to(q.size() + 10);
        do_reset();
        settle_check("R6 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule